// File: doc/BRIEF.md
# Multi-Queue Atomic Push/Pop Unit

This block holds eight separate last-in-first-out lists of buffer addresses, such as free-buffer pools, behind one shared request port. A requester pushes by giving a 3-bit queue number and two operands. The block adds the operands and stores the sum as the new top of that list. A requester pops by giving a queue number. One cycle later it receives the most recently pushed address on that list, or zero and an empty indication when the list holds nothing.

The block accepts at most one request per clock, so every push and every pop is atomic and takes effect in the order accepted. A push always wins when a push and a pop are offered in the same cycle. The pop is held off through its ready signal and stays with the requester. Every list has an empty flag and a full flag, so requesters can see the state of all lists without issuing a request. The depth of each list and the address width are parameters.

Top module: `mq_lifo_unit`

## Requirements
- R1: After reset every list is empty: q_empty_o is all ones, q_full_o is all zeros and rsp_valid_o is 0.
- R2: An accepted push stores (push_opa_i + push_opb_i) mod 2^DATA_W on list push_qid_i. One cycle later the response has rsp_valid_o=1 and rsp_pop_o=0, and rsp_data_o carries that sum.
- R3: An accepted pop of a non-empty list removes the most recently pushed entry of that list. One cycle later that entry appears on rsp_data_o with rsp_pop_o=1 and rsp_empty_o=0.
- R4: The lists are independent. A push or pop on one list never changes the contents or flags of another list.
- R5: A pop of an empty list returns rsp_data_o=0 with rsp_empty_o=1 and changes no list state.
- R6: A push to a list already holding DEPTH entries is dropped. Its response has rsp_full_o=1, and the contents of that list stay unchanged.
- R7: push_ready_o is always 1. pop_ready_o is 0 whenever push_valid_i is 1, so a simultaneous push is accepted first and the pop is not taken that cycle.
- R8: A response (rsp_valid_o=1) appears exactly one cycle after each accepted request. In any other cycle rsp_valid_o is 0.
- R9: Bit i of q_empty_o is 1 exactly when list i holds no entries. Bit i of q_full_o is 1 exactly when list i holds DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Push request |
| push_ready_o | output | 1 | Push accepted (always 1) |
| push_qid_i | input | 3 | Target list of the push |
| push_opa_i | input | DATA_W | First addend of the pushed address |
| push_opb_i | input | DATA_W | Second addend of the pushed address |
| pop_valid_i | input | 1 | Pop request |
| pop_ready_o | output | 1 | Pop accepted this cycle |
| pop_qid_i | input | 3 | Source list of the pop |
| rsp_valid_o | output | 1 | Response strobe, one cycle after acceptance |
| rsp_pop_o | output | 1 | 1: response to a pop, 0: response to a push |
| rsp_data_o | output | DATA_W | Popped address, or the pushed sum |
| rsp_empty_o | output | 1 | Pop hit an empty list |
| rsp_full_o | output | 1 | Push dropped on a full list |
| q_empty_o | output | 8 | Per-list empty flags, bit i = list i |
| q_full_o | output | 8 | Per-list full flags, bit i = list i |

## Verification
A corrupted head count or a misrouted queue select shows up at once in the per-list flags, which the bench compares on every cycle. It also shows on the very next pop response from the affected list, which returns a wrong value or a wrong empty indication. A storage write to the wrong slot stays hidden until that slot is popped. For that reason the lists are filled to full and drained completely, and the random traffic keeps the depths shallow so that pops reach back to old entries.

// File: rtl/mq_lifo_pkg.sv
package mq_lifo_pkg;
  localparam int NUM_Q = 8;
  localparam int QID_W = $clog2(NUM_Q);

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } op_e;
endpackage

// File: rtl/mq_lifo_arb.sv
module mq_lifo_arb
  import mq_lifo_pkg::*;
(
  input  logic push_valid_i,
  input  logic pop_valid_i,
  output op_e  op_o,
  output logic pop_ready_o
);
  // push has priority; one op per cycle keeps every update atomic
  always_comb begin
    if (push_valid_i)     op_o = OP_PUSH;
    else if (pop_valid_i) op_o = OP_POP;
    else                  op_o = OP_NONE;
  end

  assign pop_ready_o = !push_valid_i;
endmodule

// File: rtl/mq_lifo_slot.sv
module mq_lifo_slot #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] top_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[IDX_W'(cnt_q)] <= data_i;
  end

  assign top_o = empty_o ? '0 : mem_q[IDX_W'(cnt_q - 1'b1)];

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R5
  empty_pop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o);
  // R6
  full_push_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> full_o);
endmodule

// File: rtl/mq_lifo_unit.sv
module mq_lifo_unit
  import mq_lifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  output logic              push_ready_o,
  input  logic [QID_W-1:0]  push_qid_i,
  input  logic [DATA_W-1:0] push_opa_i,
  input  logic [DATA_W-1:0] push_opb_i,
  input  logic              pop_valid_i,
  output logic              pop_ready_o,
  input  logic [QID_W-1:0]  pop_qid_i,
  output logic              rsp_valid_o,
  output logic              rsp_pop_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_empty_o,
  output logic              rsp_full_o,
  output logic [NUM_Q-1:0]  q_empty_o,
  output logic [NUM_Q-1:0]  q_full_o
);
  op_e               op;
  logic [DATA_W-1:0] sum;
  logic [NUM_Q-1:0]  push_en, pop_en;
  logic [DATA_W-1:0] top_w [NUM_Q];

  assign push_ready_o = 1'b1;
  assign sum          = push_opa_i + push_opb_i;

  mq_lifo_arb u_arb (
    .push_valid_i (push_valid_i),
    .pop_valid_i  (pop_valid_i),
    .op_o         (op),
    .pop_ready_o  (pop_ready_o)
  );

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign push_en[i] = (op == OP_PUSH) && (push_qid_i == QID_W'(i));
    assign pop_en[i]  = (op == OP_POP)  && (pop_qid_i  == QID_W'(i));

    mq_lifo_slot #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_en[i]),
      .pop_i   (pop_en[i]),
      .data_i  (sum),
      .top_o   (top_w[i]),
      .empty_o (q_empty_o[i]),
      .full_o  (q_full_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_pop_o   <= 1'b0;
      rsp_data_o  <= '0;
      rsp_empty_o <= 1'b0;
      rsp_full_o  <= 1'b0;
    end else begin
      rsp_valid_o <= (op != OP_NONE);
      rsp_pop_o   <= (op == OP_POP);
      rsp_empty_o <= (op == OP_POP) && q_empty_o[pop_qid_i];
      rsp_full_o  <= (op == OP_PUSH) && q_full_o[push_qid_i];
      unique case (op)
        OP_PUSH: rsp_data_o <= sum;
        OP_POP:  rsp_data_o <= top_w[pop_qid_i];
        default: rsp_data_o <= '0;
      endcase
    end
  end

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i || pop_valid_i) |=> rsp_valid_o);
  // R8
  no_rsp_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_valid_i && !pop_valid_i) |=> !rsp_valid_o);
  // R7
  push_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && pop_valid_i) |=> (rsp_valid_o && !rsp_pop_o));
  // R5
  empty_pop_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_valid_i && !push_valid_i && q_empty_o[pop_qid_i])
      |=> (rsp_empty_o && rsp_data_o == '0));
  // R6
  full_push_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && q_full_o[push_qid_i]) |=> rsp_full_o);
  // R4
  one_queue_touched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_en | pop_en));
endmodule

// File: tb/sim_mq_lifo_unit.sv
`timescale 1ns/1ps
module sim_mq_lifo_unit;
  localparam int DW = 32;
  localparam int DP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_valid = 1'b0, pop_valid = 1'b0;
  logic [2:0]    push_qid = '0, pop_qid = '0;
  logic [DW-1:0] opa = '0, opb = '0;
  logic          push_ready, pop_ready;
  logic          rsp_valid, rsp_pop, rsp_empty, rsp_full;
  logic [DW-1:0] rsp_data;
  logic [7:0]    q_empty, q_full;

  int n_total = 0;
  int n_fail  = 0;
  logic [DW-1:0] mdl [8][$];

  always #10 clk = ~clk;

  mq_lifo_unit #(.DATA_W(DW), .DEPTH(DP)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .push_valid_i(push_valid), .push_ready_o(push_ready), .push_qid_i(push_qid),
    .push_opa_i(opa), .push_opb_i(opb),
    .pop_valid_i(pop_valid), .pop_ready_o(pop_ready), .pop_qid_i(pop_qid),
    .rsp_valid_o(rsp_valid), .rsp_pop_o(rsp_pop), .rsp_data_o(rsp_data),
    .rsp_empty_o(rsp_empty), .rsp_full_o(rsp_full),
    .q_empty_o(q_empty), .q_full_o(q_full)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags();
    logic [7:0] ee, ef;
    for (int i = 0; i < 8; i++) begin
      ee[i] = (mdl[i].size() == 0);
      ef[i] = (mdl[i].size() == DP);
    end
    chk("R9 empty flags", {24'd0, q_empty}, {24'd0, ee});
    chk("R9 full flags", {24'd0, q_full}, {24'd0, ef});
  endtask

  // drive at negedge, accept at posedge, check at next negedge
  task automatic step(bit pv, int pq, logic [DW-1:0] a, logic [DW-1:0] b, bit ov, int oq);
    logic [DW-1:0] e_data;
    bit e_valid, e_pop, e_empty, e_full;
    push_valid = pv; push_qid = 3'(pq); opa = a; opb = b;
    pop_valid = ov; pop_qid = 3'(oq);
    #1;
    chk("R7 push_ready", {31'd0, push_ready}, 32'd1);
    if (ov) chk("R7 pop_ready", {31'd0, pop_ready}, {31'd0, !pv});
    e_valid = pv || ov; e_pop = 0; e_empty = 0; e_full = 0; e_data = '0;
    if (pv) begin
      e_data = a + b;
      e_full = (mdl[pq].size() == DP);
      if (!e_full) mdl[pq].push_back(e_data);
    end else if (ov) begin
      e_pop = 1;
      if (mdl[oq].size() == 0) e_empty = 1;
      else e_data = mdl[oq].pop_back();
    end
    @(posedge clk);
    @(negedge clk);
    push_valid = 0; pop_valid = 0;
    chk("R8 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_valid});
    if (e_valid) begin
      chk(pv ? "R7 rsp kind" : "R3 rsp kind", {31'd0, rsp_pop}, {31'd0, e_pop});
      chk(pv ? "R2 data" : (e_empty ? "R5 data" : "R3 data"), rsp_data, e_data);
      chk("R5 rsp_empty", {31'd0, rsp_empty}, {31'd0, e_empty});
      chk("R6 rsp_full", {31'd0, rsp_full}, {31'd0, e_full});
    end
    chk_flags();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 q_empty", {24'd0, q_empty}, 32'hFF);
    chk("R1 q_full", {24'd0, q_full}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 q_empty after release", {24'd0, q_empty}, 32'hFF);

    // LIFO order and independence
    step(1, 2, 32'h100, 32'h1, 0, 0);
    step(1, 2, 32'h200, 32'h2, 0, 0);
    step(1, 5, 32'h500, 32'h5, 0, 0);
    step(1, 2, 32'h300, 32'h3, 0, 0);
    chk("R4 only lists 2 and 5 occupied", {24'd0, q_empty}, 32'hDB);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 5);
    step(0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 1, 5);       // empty
    step(0, 0, 0, 0, 1, 7);       // never used
    step(1, 3, 32'hFFFF_FFFF, 32'h2, 0, 0);  // wrap
    // push and pop together
    step(1, 1, 32'hA0, 32'h0A, 1, 2);
    step(0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 1, 1);
    // fill list 0, overflow, drain
    for (int k = 0; k < DP + 2; k++) step(1, 0, 32'(k * 16), 32'h7, 0, 0);
    step(0, 0, 0, 0, 1, 4);
    for (int k = 0; k < DP + 1; k++) step(0, 0, 0, 0, 1, 0);
    // random mixed traffic
    for (int k = 0; k < 600; k++) begin
      bit pv, ov;
      pv = ($urandom_range(0, 9) < 4);
      ov = ($urandom_range(0, 9) < 5);
      step(pv, $urandom_range(0, 7), $urandom, $urandom, ov, $urandom_range(0, 7));
    end
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule